// File: doc/BRIEF.md
# Return-Address Stack

This block is the last-in-first-out linkage store of a microprogram sequencer. It holds up to nine 12-bit words, such as subroutine return addresses or loop-start addresses. A pointer moves up on each push and down on each pop. The sequencer decides what to push and when to push or pop. The word most recently written is always shown on the top output, so a loop can branch back to it repeatedly without removing it.

Requests are plain single-cycle strobes sampled on the rising clock edge. The stack never stalls its caller, so there is no handshake. Every request is acted on in the cycle it is presented, and each result is visible on the outputs after that edge. When more than one request arrives in the same cycle, clear wins over push, and push wins over pop. An active-low flag reports when the stack holds all nine words.

Top module: `ret_link_stack`

## Requirements
- R1: After reset the stack is empty: the top output reads 0 and the full flag (active low) is high.
- R2: A push stores the push data in a new entry. That word is the top output from the next cycle, and the depth grows by one.
- R3: With no request, the pointer and the top output keep their values, so the top can be read any number of times without popping.
- R4: A pop discards the top entry. From the next cycle the top output shows the word pushed before it, or 0 if the stack is now empty.
- R5: A clear empties the stack from any depth. From the next cycle the top output reads 0 and the full flag is high.
- R6: A clear requested together with a push and/or a pop acts as a clear alone.
- R7: A pop on an empty stack leaves the pointer at zero. The top output stays 0, and a following push then pop returns the stack to empty.
- R8: The full flag is low exactly when nine words are held, and high at every depth from 0 to 8.
- R9: A push while full overwrites the top entry with the push data and leaves the depth at nine. A following pop shows the eighth word.
- R10: A push and a pop requested together, without a clear, act as a push alone.
- R11: Nine pushes followed by nine pops return the words in the reverse of their push order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_n_i | input | 1 | Asynchronous active-low reset to the empty state |
| clr_i | input | 1 | Empty the stack (highest priority) |
| push_i | input | 1 | Push push_data_i onto the stack |
| pop_i | input | 1 | Discard the top entry |
| push_data_i | input | 12 | Word to store on a push |
| top_o | output | 12 | Most recently written word; 0 while empty |
| full_n_o | output | 1 | Low when nine words are held |

## Verification
The main function is driven with single pushes and pops, with idle gaps, and with underflow pops at depth zero. A push and pop after an underflow shows whether the pointer wrapped or stayed at zero. Combined requests (clear with push, push with pop) tell the priority order apart from a simple merge of the requests. A full fill, an overwrite at depth nine and a complete drain separate a correct full threshold and saturation from off-by-one pointer or index errors. A reset in the middle of the run shows that no stale entry leaks onto the top output.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;
  localparam int unsigned STK_DEPTH = 9;
  localparam int unsigned STK_WIDTH = 12;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_PUSH  = 2'd1,
    OP_POP   = 2'd2,
    OP_CLEAR = 2'd3
  } stk_op_e;
endpackage

// File: rtl/stack_op_decode.sv
module stack_op_decode
  import ret_stack_pkg::*;
(
  input  logic    clr_i,
  input  logic    push_i,
  input  logic    pop_i,
  output stk_op_e op_o
);
  // Priority: clear (R6), then push over pop (R10).
  always_comb begin
    if (clr_i)       op_o = OP_CLEAR;
    else if (push_i) op_o = OP_PUSH;
    else if (pop_i)  op_o = OP_POP;
    else             op_o = OP_HOLD;
  end
endmodule

// File: rtl/stack_ptr.sv
module stack_ptr
  import ret_stack_pkg::*;
#(
  parameter int unsigned DEPTH = STK_DEPTH,
  localparam int unsigned PW = $clog2(DEPTH + 1),
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  stk_op_e       op_i,
  output logic [PW-1:0] sp_o,
  output logic          wr_en_o,
  output logic [IW-1:0] wr_idx_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam logic [PW-1:0] TOP_CNT = PW'(DEPTH);

  logic [PW-1:0] sp_q;

  assign full_o  = (sp_q == TOP_CNT);
  assign empty_o = (sp_q == '0);
  assign wr_en_o = (op_i == OP_PUSH);
  // A push while full rewrites the highest slot instead of growing.
  assign wr_idx_o = full_o ? IW'(DEPTH - 1) : IW'(sp_q);
  assign sp_o    = sp_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sp_q <= '0;
    end else begin
      unique case (op_i)
        OP_CLEAR: sp_q <= '0;
        OP_PUSH:  if (!full_o)  sp_q <= sp_q + 1'b1;
        OP_POP:   if (!empty_o) sp_q <= sp_q - 1'b1;
        default:  sp_q <= sp_q;
      endcase
    end
  end

  assert_ptr_bounded_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    sp_q <= TOP_CNT);

  assert_pop_empty_stays_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (empty_o && op_i == OP_POP) |=> (sp_q == '0));

  assert_push_full_saturates_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (full_o && op_i == OP_PUSH) |=> full_o);

  assert_hold_keeps_ptr_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (op_i == OP_HOLD) |=> $stable(sp_q));
endmodule

// File: rtl/stack_file.sv
module stack_file
  import ret_stack_pkg::*;
#(
  parameter int unsigned DEPTH = STK_DEPTH,
  parameter int unsigned WIDTH = STK_WIDTH,
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             wr_en_i,
  input  logic [IW-1:0]    wr_idx_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [IW-1:0]    rd_idx_i,
  output logic [WIDTH-1:0] rd_data_o
);
  logic [WIDTH-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)
        slot_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == IW'(g))
        slot_q[g] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < DEPTH; k++)
      if (rd_idx_i == IW'(k)) rd_data_o = slot_q[k];
  end
endmodule

// File: rtl/ret_link_stack.sv
module ret_link_stack
  import ret_stack_pkg::*;
#(
  parameter int unsigned DEPTH = STK_DEPTH,
  parameter int unsigned WIDTH = STK_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] push_data_i,
  output logic [WIDTH-1:0] top_o,
  output logic             full_n_o
);
  localparam int unsigned PW = $clog2(DEPTH + 1);
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  stk_op_e          op;
  logic [PW-1:0]    sp;
  logic             wr_en;
  logic [IW-1:0]    wr_idx;
  logic [IW-1:0]    rd_idx;
  logic [WIDTH-1:0] rd_data;
  logic             full;
  logic             empty;

  stack_op_decode u_dec (
    .clr_i  (clr_i),
    .push_i (push_i),
    .pop_i  (pop_i),
    .op_o   (op)
  );

  stack_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i    (clk_i),
    .rst_n_i  (rst_n_i),
    .op_i     (op),
    .sp_o     (sp),
    .wr_en_o  (wr_en),
    .wr_idx_o (wr_idx),
    .full_o   (full),
    .empty_o  (empty)
  );

  // The pointer counts entries; the top entry sits one slot below it.
  assign rd_idx = empty ? '0 : IW'(sp - 1'b1);

  stack_file #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_file (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n_i),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (push_data_i),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data)
  );

  assign top_o    = empty ? '0 : rd_data;
  assign full_n_o = ~full;

  assert_push_visible_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (push_i && !clr_i) |=> (top_o == $past(push_data_i)));

  assert_clear_empties_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    clr_i |=> (top_o == '0 && full_n_o));

  assert_idle_top_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!clr_i && !push_i && !pop_i) |=> $stable(top_o));
endmodule

// File: tb/tb_ret_link_stack.sv
`timescale 1ns/1ps
module tb_ret_link_stack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0, push = 1'b0, pop = 1'b0;
  logic [11:0] din = '0;
  logic [11:0] top;
  logic        full_n;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ret_link_stack dut (
    .clk_i(clk), .rst_n_i(rst_n), .clr_i(clr), .push_i(push), .pop_i(pop),
    .push_data_i(din), .top_o(top), .full_n_o(full_n)
  );

  // {clr, push, pop, data[11:0], expected top[11:0], expected full_n}
  localparam int NV = 15;
  localparam logic [27:0] VEC [NV] = '{
    {3'b010, 12'h111, 12'h111, 1'b1},  // R2 push
    {3'b000, 12'h000, 12'h111, 1'b1},  // R3 idle read
    {3'b010, 12'h222, 12'h222, 1'b1},  // R2 second push
    {3'b001, 12'h000, 12'h111, 1'b1},  // R4 pop reveals older
    {3'b001, 12'h000, 12'h000, 1'b1},  // R4 pop to empty
    {3'b001, 12'h000, 12'h000, 1'b1},  // R7 pop on empty
    {3'b010, 12'h0A5, 12'h0A5, 1'b1},  // R7 push after underflow
    {3'b001, 12'h000, 12'h000, 1'b1},  // R7 pointer was zero
    {3'b010, 12'h301, 12'h301, 1'b1},  // R2
    {3'b011, 12'h302, 12'h302, 1'b1},  // R10 push wins over pop
    {3'b001, 12'h000, 12'h301, 1'b1},  // R10 depth grew to two
    {3'b110, 12'h777, 12'h000, 1'b1},  // R6 clear beats push
    {3'b010, 12'h123, 12'h123, 1'b1},  // R2
    {3'b100, 12'h000, 12'h000, 1'b1},  // R5 clear
    {3'b001, 12'h000, 12'h000, 1'b1}   // R5 stays empty
  };

  task automatic chk(input string req, input logic [11:0] exp_top, input logic exp_fn);
    checks++;
    if (top !== exp_top || full_n !== exp_fn) begin
      failures++;
      $display("FAIL %s: top=%h full_n=%b expected top=%h full_n=%b",
               req, top, full_n, exp_top, exp_fn);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input logic c, input logic p, input logic o, input logic [11:0] d);
    clr = c; push = p; pop = o; din = d;
    @(posedge clk);
    #1;
    clr = 1'b0; push = 1'b0; pop = 1'b0; din = '0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset state", 12'h000, 1'b1);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][27], VEC[i][26], VEC[i][25], VEC[i][24:13]);
      chk($sformatf("table row %0d", i), VEC[i][12:1], VEC[i][0]);
    end

    // R8: fill, full flag only at nine
    for (int i = 0; i < 9; i++) begin
      step(1'b0, 1'b1, 1'b0, 12'h900 + 12'(i));
      chk("R8 fill depth", 12'h900 + 12'(i), (i == 8) ? 1'b0 : 1'b1);
    end
    // R9: overwrite while full
    step(1'b0, 1'b1, 1'b0, 12'hFFF);
    chk("R9 overwrite top", 12'hFFF, 1'b0);
    step(1'b0, 1'b0, 1'b0, 12'h000);
    chk("R3 idle while full", 12'hFFF, 1'b0);
    step(1'b0, 1'b0, 1'b1, 12'h000);
    chk("R9 pop shows eighth", 12'h907, 1'b1);
    // R11: drain in reverse order
    for (int i = 6; i >= 0; i--) begin
      step(1'b0, 1'b0, 1'b1, 12'h000);
      chk("R11 reverse order", 12'h900 + 12'(i), 1'b1);
    end
    step(1'b0, 1'b0, 1'b1, 12'h000);
    chk("R11 drained", 12'h000, 1'b1);

    // R5: clear from full
    for (int i = 0; i < 9; i++) step(1'b0, 1'b1, 1'b0, 12'h400 + 12'(i));
    chk("R8 full again", 12'h408, 1'b0);
    step(1'b1, 1'b0, 1'b1, 12'h000);
    chk("R5 R6 clear from full", 12'h000, 1'b1);
    step(1'b0, 1'b1, 1'b0, 12'h055);
    chk("R5 push after clear", 12'h055, 1'b1);
    step(1'b0, 1'b0, 1'b1, 12'h000);
    chk("R5 one entry after clear", 12'h000, 1'b1);

    // R1: reset mid-run
    step(1'b0, 1'b1, 1'b0, 12'hABC);
    step(1'b0, 1'b1, 1'b0, 12'hDEF);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset mid-run", 12'h000, 1'b1);
    step(1'b0, 1'b0, 1'b1, 12'h000);
    chk("R1 no stale entry", 12'h000, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule